// File: doc/BRIEF.md
# Trimmed Seconds Prescaler with Frequency-Test Output

This block turns a 32.768 kHz oscillator enable into a one-second tick for a real-time clock. The tick period can be trimmed by a signed calibration value. Each step of the value adds or removes a fixed number of oscillator cycles over a repeating window of seconds. The added or removed cycles are spread across the seconds of the window, so no single second takes the whole correction.

A second output, taken from a separate untrimmed divider, toggles at 512 Hz. A technician measures this output to find the raw oscillator error, and calibration cannot hide that error. A small register port holds the calibration value and the control bits, and shows a battery-weak flag. The flag is sampled from a comparator input at the end of each reset.

There are two reset inputs. The first is a full power-on or battery-attach reset. The second is a power-cycle reset, which runs while the battery keeps the time-keeping state alive.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: With a calibration magnitude of 0, `sec_tick` pulses once every `DIV_SEC` cycles in which `osc_en` is high. The pulse is one clock wide and appears the clock after the enable that completes the second.
- R2: The calibration register at address 0 holds a sign in bit 5 and a magnitude m in bits 4:0. With sign 0 (slow), second k of the window (k = 0 .. `WIN_SEC`-1) lasts `DIV_SEC` + floor((k+1)·T/`WIN_SEC`) − floor(k·T/`WIN_SEC`) enables, where T = m·`STEP_CNT`. The window as a whole therefore gains exactly T enables.
- R3: With sign 1 (fast), the same per-second amount is subtracted instead of added.
- R4: The halt bit (bit 0 at address 1) freezes the seconds prescaler, and no `sec_tick` is produced while it is set. Clearing it resumes counting from the held count, so the enables counted before and after the halt add up to one normal period.
- R5: `ftest_out` toggles once every `FT_HALF` enables only while the frequency-test bit (bit 1 at address 1) is 1 and halt is 0. Otherwise it is driven 0 from the next clock on.
- R6: Writing the calibration register does not change the spacing of `ftest_out` toggles.
- R7: Register map and readback. Address 0 reads {2'b00, calibration[5:0]}, and write bits 7:6 are dropped. Address 1 reads {2'b00, control[5:0]}, with bit 0 = halt, 1 = ftest, 2 = write-protect, 3 = timer enable, 4 = timer flag and 5 = sleep. Address 3 reads 0, and writes to it are dropped. `reg_rdata` follows `reg_addr` in the same cycle, and a write lands on the clock edge where `reg_we` is high.
- R8: While `por` is high, the calibration and control registers, the seconds count, the window index and the battery flag are all cleared.
- R9: While `pcyc` is high, ftest and write-protect clear. Halt, timer enable, timer flag, sleep, calibration and the prescaler state keep their values, and register writes are dropped.
- R10: Address 2 reads the battery-weak flag in bit 7, with bits 6:0 reading 0. The flag loads `batt_weak` on the clock after `por` or `pcyc` is released, and it holds that value at all other times. Writes to address 2 are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por | input | 1 | Synchronous power-on / battery-attach reset, active high |
| pcyc | input | 1 | Synchronous power-cycle reset, active high |
| osc_en | input | 1 | One-clock enable per 32.768 kHz oscillator cycle |
| batt_weak | input | 1 | Battery comparator result, 1 = below threshold |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| sec_tick | output | 1 | One-clock pulse per (trimmed) second |
| ftest_out | output | 1 | Untrimmed frequency-test square wave |

## Verification
The bench builds the block with `DIV_SEC`=64, `FT_HALF`=2, `WIN_SEC`=4 and `STEP_CNT`=2. This makes a trimmed second about 64 enables long and a full calibration window 4 seconds long. Every per-second adjustment, the cyclic window sum and the full-scale fast trim (48/49-enable seconds) can then be measured many times within a few thousand clocks. The small test half-period lets toggle spacing be checked across calibration writes and halt transitions. The untrimmed and trimmed chains keep separate counters at any size, so the reduced sizes exercise the same logic as the defaults.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

  localparam logic [1:0] ADDR_CAL  = 2'd0;
  localparam logic [1:0] ADDR_CTL  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic sleep;
    logic tmr_flag;
    logic tmr_en;
    logic wprot;
    logic ftest;
    logic halt;
  } ctl_t;

  typedef struct packed {
    logic       sign;
    logic [4:0] mag;
  } cal_t;

  // Cycles to add or remove in second k of a window of 2**wlog seconds,
  // spreading total cycles evenly over the window.
  function automatic int unsigned spread_adj(input int unsigned k,
                                             input int unsigned total,
                                             input int unsigned wlog);
    int unsigned upper;
    int unsigned lower;
    upper = ((k + 1) * total) >> wlog;
    lower = (k * total) >> wlog;
    return upper - lower;
  endfunction

endpackage

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_trim_pkg::*;
(
  input  logic       clk,
  input  logic       por,
  input  logic       pcyc,
  input  logic       batt_weak,
  input  logic       we,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output ctl_t       ctl,
  output cal_t       cal,
  output logic       batt_low,
  output logic       rst_release
);

  ctl_t ctl_q;
  cal_t cal_q;
  logic bl_q;
  logic rst_any;
  logic rst_d;
  logic unused_wd;

  assign rst_any     = por | pcyc;
  assign rst_release = rst_d & ~rst_any;
  assign unused_wd   = ^wdata[7:6];

  always_ff @(posedge clk) begin
    if (por) rst_d <= 1'b1;
    else     rst_d <= rst_any;
  end

  always_ff @(posedge clk) begin
    if (por) begin
      ctl_q <= '0;
      cal_q <= '0;
    end else if (pcyc) begin
      ctl_q.ftest <= 1'b0;
      ctl_q.wprot <= 1'b0;
    end else if (we) begin
      case (addr)
        ADDR_CAL: cal_q <= cal_t'(wdata[5:0]);
        ADDR_CTL: ctl_q <= ctl_t'(wdata[5:0]);
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (por)              bl_q <= 1'b0;
    else if (rst_release) bl_q <= batt_weak;
  end

  always_comb begin
    case (addr)
      ADDR_CAL:  rdata = {2'b00, cal_q};
      ADDR_CTL:  rdata = {2'b00, ctl_q};
      ADDR_STAT: rdata = {bl_q, 7'b0};
      default:   rdata = 8'h00;
    endcase
  end

  assign ctl      = ctl_q;
  assign cal      = cal_q;
  assign batt_low = bl_q;

endmodule

// File: rtl/rtc_base_divider.sv
module rtc_base_divider #(
  parameter int unsigned FT_HALF = 32
) (
  input  logic clk,
  input  logic por,
  input  logic osc_en,
  input  logic active,
  output logic ft_out
);

  localparam int FW = $clog2(FT_HALF + 1);
  localparam logic [FW-1:0] LAST = FW'(FT_HALF - 1);

  logic [FW-1:0] cnt_q;
  logic          sq_q;
  logic          ft_flip;

  assign ft_flip = active & osc_en & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (por || !active) begin
      cnt_q <= '0;
      sq_q  <= 1'b0;
    end else if (osc_en) begin
      if (ft_flip) begin
        cnt_q <= '0;
        sq_q  <= ~sq_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ft_out = sq_q;

endmodule

// File: rtl/rtc_trim_counter.sv
module rtc_trim_counter
  import rtc_trim_pkg::*;
#(
  parameter int unsigned DIV_SEC  = 32768,
  parameter int unsigned WIN_SEC  = 64,
  parameter int unsigned STEP_CNT = 4
) (
  input  logic clk,
  input  logic por,
  input  logic osc_en,
  input  logic halt,
  input  cal_t cal,
  output logic tick
);

  localparam int unsigned MAX_TOT = 31 * STEP_CNT;
  localparam int unsigned LIM_MAX = DIV_SEC + MAX_TOT;
  localparam int CW = $clog2(LIM_MAX + 1);
  localparam int WL = $clog2(WIN_SEC);

  logic [CW-1:0] cnt_q;
  logic [WL-1:0] sec_q;
  logic          tick_q;
  int unsigned   adj_w;
  logic [CW-1:0] limit_w;
  logic          run_w;
  logic          sec_wrap;

  always_comb begin
    adj_w   = spread_adj(32'(sec_q), 32'(cal.mag) * STEP_CNT, WL);
    limit_w = cal.sign ? CW'(DIV_SEC - adj_w) : CW'(DIV_SEC + adj_w);
  end

  assign run_w    = osc_en & ~halt;
  assign sec_wrap = run_w & (cnt_q >= (limit_w - 1'b1));

  always_ff @(posedge clk) begin
    if (por) begin
      cnt_q  <= '0;
      sec_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= sec_wrap;
      if (sec_wrap) begin
        cnt_q <= '0;
        sec_q <= sec_q + 1'b1;
      end else if (run_w) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign tick = tick_q;

endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
  import rtc_trim_pkg::*;
#(
  parameter int unsigned DIV_SEC  = 32768,
  parameter int unsigned FT_HALF  = 32,
  parameter int unsigned WIN_SEC  = 64,
  parameter int unsigned STEP_CNT = 4
) (
  input  logic       clk,
  input  logic       por,
  input  logic       pcyc,
  input  logic       osc_en,
  input  logic       batt_weak,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       sec_tick,
  output logic       ftest_out
);

  ctl_t ctl_w;
  cal_t cal_w;
  logic batt_low;
  logic rst_release;
  logic ft_active;
  logic st_halt;
  logic st_ftest;
  logic st_wprot;

  rtc_ctrl_regs u_regs (
    .clk        (clk),
    .por        (por),
    .pcyc       (pcyc),
    .batt_weak  (batt_weak),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .ctl        (ctl_w),
    .cal        (cal_w),
    .batt_low   (batt_low),
    .rst_release(rst_release)
  );

  assign st_halt   = ctl_w.halt;
  assign st_ftest  = ctl_w.ftest;
  assign st_wprot  = ctl_w.wprot;
  assign ft_active = st_ftest & ~st_halt;

  rtc_base_divider #(.FT_HALF(FT_HALF)) u_base (
    .clk    (clk),
    .por    (por),
    .osc_en (osc_en),
    .active (ft_active),
    .ft_out (ftest_out)
  );

  rtc_trim_counter #(
    .DIV_SEC (DIV_SEC),
    .WIN_SEC (WIN_SEC),
    .STEP_CNT(STEP_CNT)
  ) u_trim (
    .clk    (clk),
    .por    (por),
    .osc_en (osc_en),
    .halt   (st_halt),
    .cal    (cal_w),
    .tick   (sec_tick)
  );

endmodule

// File: rtl/rtc_trim_prescaler_chk.sv
module rtc_trim_prescaler_chk (
  input logic clk,
  input logic por,
  input logic pcyc,
  input logic osc_en,
  input logic halt,
  input logic ftest,
  input logic wprot,
  input logic batt_low,
  input logic ft_active,
  input logic rst_release,
  input logic sec_tick,
  input logic ftest_out
);

  // R5: test output drops when not enabled
  p_ft_quiet_r5: assert property (@(posedge clk) disable iff (por)
    !ft_active |=> !ftest_out);

  // R5: a rising test edge follows an oscillator enable
  p_ft_on_enable_r5: assert property (@(posedge clk) disable iff (por)
    $rose(ftest_out) |-> $past(osc_en));

  // R4: a tick only follows a running enable
  p_tick_running_r4: assert property (@(posedge clk) disable iff (por)
    sec_tick |-> ($past(osc_en) && !$past(halt)));

  // R9: power cycle clears ftest and write-protect
  p_pcyc_clear_r9: assert property (@(posedge clk) disable iff (por)
    pcyc |=> (!ftest && !wprot));

  // R10: battery flag moves only after a reset release
  p_bl_hold_r10: assert property (@(posedge clk) disable iff (por)
    !$past(rst_release) |-> $stable(batt_low));

endmodule

bind rtc_trim_prescaler rtc_trim_prescaler_chk u_chk (
  .clk        (clk),
  .por        (por),
  .pcyc       (pcyc),
  .osc_en     (osc_en),
  .halt       (st_halt),
  .ftest      (st_ftest),
  .wprot      (st_wprot),
  .batt_low   (batt_low),
  .ft_active  (ft_active),
  .rst_release(rst_release),
  .sec_tick   (sec_tick),
  .ftest_out  (ftest_out)
);

// File: tb/rtc_trim_prescaler_tb_top.sv
module rtc_trim_prescaler_tb_top;

  localparam int CLK_NS = 10;
  localparam int B_DIV  = 64;
  localparam int B_FTH  = 2;
  localparam int B_WIN  = 4;
  localparam int B_STEP = 2;
  localparam int WDOG   = 150000;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       pcyc = 1'b0;
  logic       osc_en = 1'b0;
  logic       batt_weak = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sec_tick;
  logic       ftest_out;

  int  n_chk = 0;
  int  n_fail = 0;
  int  cyc = 0;
  bit  gate = 1'b0;
  bit  halt_tb = 1'b0;
  bit  m_sign = 1'b0;
  int  m_mag = 0;
  int  en_cnt = 0;
  int  ft_en = 0;
  int  last_period = 0;
  int  exp_last = 0;
  int  sec_k = 0;
  int  tick_total = 0;
  int  ft_iv = 0;
  int  ft_changes = 0;
  int  phase = 0;
  logic ft_prev = 1'b0;

  rtc_trim_prescaler #(
    .DIV_SEC (B_DIV),
    .FT_HALF (B_FTH),
    .WIN_SEC (B_WIN),
    .STEP_CNT(B_STEP)
  ) dut_i (
    .clk      (clk),
    .por      (por),
    .pcyc     (pcyc),
    .osc_en   (osc_en),
    .batt_weak(batt_weak),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .sec_tick (sec_tick),
    .ftest_out(ftest_out)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic int exp_period(input bit s, input int m, input int k);
    int tot;
    int lo;
    int hi;
    tot = m * B_STEP;
    lo = (k * tot) / B_WIN;
    hi = ((k + 1) * tot) / B_WIN;
    return s ? (B_DIV - (hi - lo)) : (B_DIV + (hi - lo));
  endfunction

  // Monitor and enable generator, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (osc_en && !halt_tb) en_cnt++;
    if (osc_en) ft_en++;
    if (sec_tick) begin
      last_period = en_cnt;
      en_cnt = 0;
      exp_last = exp_period(m_sign, m_mag, sec_k);
      sec_k = (sec_k + 1) % B_WIN;
      tick_total++;
    end
    if (ftest_out !== ft_prev) begin
      ft_iv = ft_en;
      ft_en = 0;
      ft_prev = ftest_out;
      ft_changes++;
    end
    phase = (phase + 1) % 3;
    osc_en = gate && (phase != 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    gate = 1'b0;
    @(negedge clk);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 2'd0) begin m_sign = d[5]; m_mag = int'(d[4:0]); end
    if (a == 2'd1) halt_tb = d[0];
    gate = 1'b1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_tick();
    int t0;
    t0 = tick_total;
    while (tick_total == t0) @(posedge clk);
  endtask

  task automatic wait_ft();
    int c0;
    c0 = ft_changes;
    while (ft_changes == c0) @(posedge clk);
  endtask

  task automatic do_por(input logic b);
    gate = 1'b0;
    batt_weak = b;
    @(negedge clk); por = 1'b1;
    repeat (3) @(negedge clk);
    por = 1'b0;
    en_cnt = 0; sec_k = 0; m_sign = 1'b0; m_mag = 0; halt_tb = 1'b0;
    @(negedge clk);
    gate = 1'b1;
  endtask

  task automatic do_pcyc(input logic b);
    gate = 1'b0;
    batt_weak = b;
    @(negedge clk); pcyc = 1'b1;
    repeat (2) @(negedge clk);
    pcyc = 1'b0;
    @(negedge clk);
    gate = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_por(1'b1);
    rd(2'd0, d); chk(d == 8'h00, "R8 cal after por", int'(d), 0);
    rd(2'd1, d); chk(d == 8'h00, "R8 ctl after por", int'(d), 0);
    rd(2'd2, d); chk(d == 8'h80, "R10 batt flag after por", int'(d), 128);
    chk(ftest_out == 1'b0, "R5 ftest_out after por", int'(ftest_out), 0);
  endtask

  task automatic t_plain();
    for (int i = 0; i < 6; i++) begin
      wait_tick();
      chk(last_period == B_DIV, "R1 untrimmed period", last_period, B_DIV);
    end
  endtask

  task automatic t_slow();
    logic [7:0] d;
    int sum;
    wait_tick();
    wr(2'd0, 8'hC5);
    rd(2'd0, d); chk(d == 8'h05, "R7 cal top bits dropped", int'(d), 5);
    wait_tick();
    chk(last_period == exp_last, "R2 slow first", last_period, exp_last);
    sum = 0;
    for (int i = 0; i < B_WIN; i++) begin
      wait_tick();
      sum += last_period;
      chk(last_period == exp_last, "R2 slow per second", last_period, exp_last);
    end
    chk(sum == B_WIN * B_DIV + 5 * B_STEP, "R2 slow window sum", sum, B_WIN * B_DIV + 5 * B_STEP);
  endtask

  task automatic t_fast();
    int sum;
    wait_tick();
    wr(2'd0, 8'h3F);
    wait_tick();
    sum = 0;
    for (int i = 0; i < B_WIN; i++) begin
      wait_tick();
      sum += last_period;
      chk(last_period == exp_last, "R3 fast full scale", last_period, exp_last);
    end
    chk(sum == B_WIN * B_DIV - 31 * B_STEP, "R3 fast window sum", sum, B_WIN * B_DIV - 31 * B_STEP);
    wr(2'd0, 8'h21);
    for (int i = 0; i < B_WIN + 1; i++) begin
      wait_tick();
      chk(last_period == exp_last, "R3 fast magnitude 1", last_period, exp_last);
    end
  endtask

  task automatic t_ftest();
    int c0;
    wr(2'd1, 8'h02);
    wait_ft();
    for (int i = 0; i < 4; i++) begin
      wait_ft();
      chk(ft_iv == B_FTH, "R5 test toggle spacing", ft_iv, B_FTH);
    end
    wr(2'd0, 8'h1F);
    for (int i = 0; i < 3; i++) begin
      wait_ft();
      chk(ft_iv == B_FTH, "R6 spacing after cal write", ft_iv, B_FTH);
    end
    wr(2'd0, 8'h3A);
    for (int i = 0; i < 3; i++) begin
      wait_ft();
      chk(ft_iv == B_FTH, "R6 spacing after second cal write", ft_iv, B_FTH);
    end
    wr(2'd1, 8'h03);
    repeat (10) @(negedge clk);
    c0 = ft_changes;
    repeat (40) @(negedge clk);
    chk(ftest_out == 1'b0 && ft_changes == c0, "R5 quiet while halted", ft_changes - c0, 0);
    wr(2'd1, 8'h00);
    repeat (10) @(negedge clk);
    c0 = ft_changes;
    repeat (40) @(negedge clk);
    chk(ftest_out == 1'b0 && ft_changes == c0, "R5 quiet with ftest clear", ft_changes - c0, 0);
  endtask

  task automatic t_halt();
    int t0;
    wait_tick();
    repeat (20) @(negedge clk);
    t0 = tick_total;
    wr(2'd1, 8'h01);
    repeat (300) @(negedge clk);
    chk(tick_total == t0, "R4 no tick while halted", tick_total - t0, 0);
    wr(2'd1, 8'h00);
    wait_tick();
    chk(last_period == exp_last, "R4 resume from held count", last_period, exp_last);
  endtask

  task automatic t_status();
    logic [7:0] d;
    wr(2'd2, 8'h00);
    rd(2'd2, d); chk(d == 8'h80, "R10 status write dropped", int'(d), 128);
    wr(2'd3, 8'hFF);
    rd(2'd3, d); chk(d == 8'h00, "R7 reserved reads zero", int'(d), 0);
  endtask

  task automatic t_pcyc();
    logic [7:0] d;
    wr(2'd0, 8'h25);
    wr(2'd1, 8'h3E);
    do_pcyc(1'b0);
    rd(2'd1, d); chk(d == 8'h38, "R9 ctl after power cycle", int'(d), 56);
    rd(2'd0, d); chk(d == 8'h25, "R9 cal kept", int'(d), 37);
    rd(2'd2, d); chk(d == 8'h00, "R10 batt flag reloaded good", int'(d), 0);
    repeat (4) @(negedge clk);
    chk(ftest_out == 1'b0, "R9 ftest cleared output", int'(ftest_out), 0);
    wait_tick();
    wait_tick();
    chk(last_period == exp_last, "R9 prescaler state kept", last_period, exp_last);
    wr(2'd1, 8'h01);
    do_pcyc(1'b1);
    rd(2'd1, d); chk(d == 8'h01, "R9 halt kept", int'(d), 1);
    rd(2'd2, d); chk(d == 8'h80, "R10 batt flag reloaded weak", int'(d), 128);
    do_por(1'b0);
    rd(2'd0, d); chk(d == 8'h00, "R8 cal cleared", int'(d), 0);
    rd(2'd1, d); chk(d == 8'h00, "R8 ctl cleared", int'(d), 0);
    rd(2'd2, d); chk(d == 8'h00, "R8 batt flag good", int'(d), 0);
    wait_tick();
    chk(last_period == B_DIV, "R8 count restarts", last_period, B_DIV);
  endtask

  initial begin
    while (cyc < WDOG) @(negedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_plain();
    t_slow();
    t_fast();
    t_ftest();
    t_halt();
    t_status();
    t_pcyc();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule